// File: doc/BRIEF.md
# Dynamic Thermal Management Controller

This block watches a stream of digital temperature samples and decides when a chip must be slowed down to stay within its cooling capacity. Samples arrive with a valid strobe and are collected into windows of a fixed number of samples. Only the average of each completed window is compared against a programmable trigger level. A short spike inside a window is therefore smoothed out and does not fire the response.

When a window average reaches the trigger, the controller runs a fixed sequence of timed phases. An initiation phase models the time taken to notice and hand off the event. A response phase models the time taken to apply the throttle. A hold phase keeps the throttle engaged for a programmable policy window. At the end of each policy window the latest window average is checked against a release level, which is programmed at or below the trigger. If the average is still at or above the release level, a fresh policy window starts. If it is below, a shutoff phase models the time taken to undo the throttle, and the controller then returns to idle.

Each phase length is programmable, and a length of zero skips that phase. Two counters record how many times the throttle was engaged and how many cycles were spent in the hold phase. A new configuration is accepted only while the controller is idle.

Top module: `thermal_guard`

## Requirements
- R1: After a synchronous active-high reset, `phase_o` is 0 (idle), `throttle_o` is low, and both counters are zero. The reset configuration is trigger 200, release 180, initiation 4, response 4, policy 16 and shutoff 4 cycles.
- R2: Temperature is judged only per window of 2^AVG_LOG2 valid samples (4 by default). The window result is the floor of the sample sum divided by the sample count. For example, samples 255,150,150,150 give 176, which does not trigger at a level of 200.
- R3: From idle, a completed window whose average is greater than or equal to the trigger level starts the sequence. An average one below the trigger does not start it.
- R4: `phase_o` encodes idle=0, initiation=1, response=2, hold=3, shutoff=4. Phases run in that order, and initiation, response and hold each last exactly their programmed number of cycles.
- R5: A programmed length of zero skips the initiation, response or shutoff phase. A policy length of zero acts as one cycle.
- R6: At the end of every policy window, the most recent window average is compared with the release level. If it is greater than or equal to the release level, another full policy window follows. Otherwise the controller leaves the hold phase. Averages between the release and trigger levels keep the throttle engaged.
- R7: `throttle_o` is high exactly while `phase_o` is 3 or 4.
- R8: The shutoff phase lasts its programmed number of cycles, and the controller then returns to idle.
- R9: A `cfg_load` pulse copies all six configuration inputs only when `phase_o` is 0. A pulse in any other phase is ignored entirely.
- R10: `engage_cnt_o` counts entries into the hold phase from another phase. `active_cyc_o` counts the cycles spent in the hold phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_valid | input | 1 | Temperature sample strobe |
| temp_data | input | TEMP_W | Temperature sample |
| cfg_load | input | 1 | Load configuration (idle only) |
| cfg_trigger | input | TEMP_W | Trigger level |
| cfg_release | input | TEMP_W | Release level for the policy re-check |
| cfg_init_dly | input | DLY_W | Initiation phase length in cycles |
| cfg_resp_dly | input | DLY_W | Response phase length in cycles |
| cfg_policy_dly | input | DLY_W | Policy window length in cycles |
| cfg_shut_dly | input | DLY_W | Shutoff phase length in cycles |
| throttle_o | output | 1 | Throttle request |
| phase_o | output | 3 | Current phase code |
| engage_cnt_o | output | CNT_W | Number of engagements |
| active_cyc_o | output | CNT_W | Cycles spent in the hold phase |

## Verification
The bench goes after the comparison edges: a window averaging exactly the trigger must engage, one averaging one below must not, and a single hot sample in a cool window must not. A design that compared raw samples, or used a strict comparison, would either throttle on the spike or miss the exact-level case. The bench also checks the re-check boundary at exactly the release level and the middle band between release and trigger. A design without hysteresis, or one that re-checked against the trigger, would drop out of the hold phase early. Further cases are an all-zero configuration, where a design that did not skip phases would show extra phases or a stall, and a configuration load while busy, where a design that did not lock its settings would lengthen the next initiation phase.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_INIT = 3'd1,
    PH_RESP = 3'd2,
    PH_HOLD = 3'd3,
    PH_SHUT = 3'd4
  } phase_e;
endpackage

// File: rtl/dtm_window.sv
module dtm_window #(
  parameter int TEMP_W   = 8,
  parameter int AVG_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [TEMP_W-1:0] smp_data,
  output logic [TEMP_W-1:0] avg_q,
  output logic              done_q
);
  localparam int SUM_W = TEMP_W + AVG_LOG2;

  logic [AVG_LOG2-1:0] idx_q;
  logic [SUM_W-1:0]    acc_q;
  logic [SUM_W-1:0]    acc_n;
  logic                last_smp;

  assign acc_n    = acc_q + SUM_W'(smp_data);
  assign last_smp = &idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      acc_q  <= '0;
      avg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (smp_valid) begin
        if (last_smp) begin
          avg_q  <= acc_n[SUM_W-1:AVG_LOG2];
          done_q <= 1'b1;
          acc_q  <= '0;
          idx_q  <= '0;
        end else begin
          acc_q <= acc_n;
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R2
  done_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(smp_valid));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q || $past(smp_valid));
endmodule

// File: rtl/dtm_seq.sv
module dtm_seq
  import dtm_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int DLY_W       = 16,
  parameter int DEF_TRIGGER = 200,
  parameter int DEF_RELEASE = 180,
  parameter int DEF_INIT    = 4,
  parameter int DEF_RESP    = 4,
  parameter int DEF_POLICY  = 16,
  parameter int DEF_SHUT    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_done,
  input  logic [TEMP_W-1:0] win_avg,
  input  logic              cfg_load,
  input  logic [TEMP_W-1:0] cfg_trigger,
  input  logic [TEMP_W-1:0] cfg_release,
  input  logic [DLY_W-1:0]  cfg_init_dly,
  input  logic [DLY_W-1:0]  cfg_resp_dly,
  input  logic [DLY_W-1:0]  cfg_policy_dly,
  input  logic [DLY_W-1:0]  cfg_shut_dly,
  output phase_e            phase_q,
  output logic              throttle_q
);
  typedef struct packed {
    phase_e           ph;
    logic [DLY_W-1:0] n;
  } step_t;

  logic [TEMP_W-1:0] trig_q, rel_q;
  logic [DLY_W-1:0]  init_q, resp_q, pol_q, shut_q;
  logic [DLY_W-1:0]  cnt_q;
  logic [DLY_W-1:0]  pol_eff;
  step_t             go_hold, go_resp, go_init, go_shut, nxt;
  logic              cnt_last;

  assign pol_eff  = (pol_q == '0) ? DLY_W'(1) : pol_q;
  assign cnt_last = (cnt_q <= DLY_W'(1));

  // Entry points of the chain, each skipping a zero-length phase
  always_comb begin
    go_hold = '{ph: PH_HOLD, n: pol_eff};
    go_resp = (resp_q != '0) ? step_t'{ph: PH_RESP, n: resp_q} : go_hold;
    go_init = (init_q != '0) ? step_t'{ph: PH_INIT, n: init_q} : go_resp;
    go_shut = (shut_q != '0) ? step_t'{ph: PH_SHUT, n: shut_q}
                             : step_t'{ph: PH_IDLE, n: '0};
  end

  always_comb begin
    nxt = '{ph: phase_q, n: cnt_q - 1'b1};
    unique case (phase_q)
      PH_IDLE: begin
        nxt.n = '0;
        if (win_done && (win_avg >= trig_q)) nxt = go_init;
      end
      PH_INIT: if (cnt_last) nxt = go_resp;
      PH_RESP: if (cnt_last) nxt = go_hold;
      PH_HOLD: if (cnt_last) nxt = (win_avg >= rel_q) ? go_hold : go_shut;
      PH_SHUT: if (cnt_last) nxt = '{ph: PH_IDLE, n: '0};
      default: nxt = '{ph: PH_IDLE, n: '0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      throttle_q <= 1'b0;
    end else begin
      phase_q    <= nxt.ph;
      cnt_q      <= nxt.n;
      throttle_q <= (nxt.ph == PH_HOLD) || (nxt.ph == PH_SHUT);
    end
  end

  // Configuration shadow: written only while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= TEMP_W'(DEF_TRIGGER);
      rel_q  <= TEMP_W'(DEF_RELEASE);
      init_q <= DLY_W'(DEF_INIT);
      resp_q <= DLY_W'(DEF_RESP);
      pol_q  <= DLY_W'(DEF_POLICY);
      shut_q <= DLY_W'(DEF_SHUT);
    end else if (cfg_load && (phase_q == PH_IDLE)) begin
      trig_q <= cfg_trigger;
      rel_q  <= cfg_release;
      init_q <= cfg_init_dly;
      resp_q <= cfg_resp_dly;
      pol_q  <= cfg_policy_dly;
      shut_q <= cfg_shut_dly;
    end
  end

  // R3
  idle_needs_window_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && !win_done) |=> phase_q == PH_IDLE);

  // R4
  phase_dwell_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE && cnt_q > DLY_W'(1)) |=> $stable(phase_q));

  // R7
  throttle_phase_chk: assert property (@(posedge clk) disable iff (rst)
    throttle_q |-> (phase_q == PH_HOLD || phase_q == PH_SHUT));

  // R9
  cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE) |=> ($stable(trig_q) && $stable(init_q) && $stable(pol_q)));

  // R8
  shut_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SHUT && cnt_last) |=> phase_q == PH_IDLE);
endmodule

// File: rtl/dtm_stats.sv
module dtm_stats
  import dtm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  phase_e           phase,
  output logic [CNT_W-1:0] engage_q,
  output logic [CNT_W-1:0] active_q
);
  logic was_hold_q;
  logic in_hold;

  assign in_hold = (phase == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      was_hold_q <= 1'b0;
      engage_q   <= '0;
      active_q   <= '0;
    end else begin
      was_hold_q <= in_hold;
      if (in_hold && !was_hold_q) engage_q <= engage_q + 1'b1;
      if (in_hold)                active_q <= active_q + 1'b1;
    end
  end

  // R10
  engage_le_active_chk: assert property (@(posedge clk) disable iff (rst)
    engage_q <= active_q);

  // R10
  engage_step_chk: assert property (@(posedge clk) disable iff (rst)
    (engage_q != $past(engage_q)) |-> $past(phase == PH_HOLD));
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import dtm_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int AVG_LOG2    = 2,
  parameter int DLY_W       = 16,
  parameter int CNT_W       = 32,
  parameter int DEF_TRIGGER = 200,
  parameter int DEF_RELEASE = 180,
  parameter int DEF_INIT    = 4,
  parameter int DEF_RESP    = 4,
  parameter int DEF_POLICY  = 16,
  parameter int DEF_SHUT    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] temp_data,
  input  logic              cfg_load,
  input  logic [TEMP_W-1:0] cfg_trigger,
  input  logic [TEMP_W-1:0] cfg_release,
  input  logic [DLY_W-1:0]  cfg_init_dly,
  input  logic [DLY_W-1:0]  cfg_resp_dly,
  input  logic [DLY_W-1:0]  cfg_policy_dly,
  input  logic [DLY_W-1:0]  cfg_shut_dly,
  output logic              throttle_o,
  output logic [2:0]        phase_o,
  output logic [CNT_W-1:0]  engage_cnt_o,
  output logic [CNT_W-1:0]  active_cyc_o
);
  logic [TEMP_W-1:0] win_avg;
  logic              win_done;
  phase_e            phase;

  dtm_window #(.TEMP_W(TEMP_W), .AVG_LOG2(AVG_LOG2)) u_window (
    .clk(clk), .rst(rst), .smp_valid(temp_valid), .smp_data(temp_data),
    .avg_q(win_avg), .done_q(win_done)
  );

  dtm_seq #(
    .TEMP_W(TEMP_W), .DLY_W(DLY_W),
    .DEF_TRIGGER(DEF_TRIGGER), .DEF_RELEASE(DEF_RELEASE),
    .DEF_INIT(DEF_INIT), .DEF_RESP(DEF_RESP),
    .DEF_POLICY(DEF_POLICY), .DEF_SHUT(DEF_SHUT)
  ) u_seq (
    .clk(clk), .rst(rst), .win_done(win_done), .win_avg(win_avg),
    .cfg_load(cfg_load), .cfg_trigger(cfg_trigger), .cfg_release(cfg_release),
    .cfg_init_dly(cfg_init_dly), .cfg_resp_dly(cfg_resp_dly),
    .cfg_policy_dly(cfg_policy_dly), .cfg_shut_dly(cfg_shut_dly),
    .phase_q(phase), .throttle_q(throttle_o)
  );

  dtm_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst), .phase(phase),
    .engage_q(engage_cnt_o), .active_q(active_cyc_o)
  );

  assign phase_o = phase;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (phase_o == 3'd0 && !throttle_o && engage_cnt_o == '0));
endmodule

// File: tb/thermal_guard_tb.sv
module thermal_guard_tb;
  typedef struct {
    int ph;
    int dwell;
    bit mult;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        temp_valid = 1'b0;
  logic [7:0]  temp_data = '0;
  logic        cfg_load = 1'b0;
  logic [7:0]  cfg_trigger = '0, cfg_release = '0;
  logic [15:0] cfg_init_dly = '0, cfg_resp_dly = '0, cfg_policy_dly = '0, cfg_shut_dly = '0;
  logic        throttle_o;
  logic [2:0]  phase_o;
  logic [31:0] engage_cnt_o, active_cyc_o;

  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  int   hold_total = 0;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  thermal_guard u_dut (
    .clk(clk), .rst(rst), .temp_valid(temp_valid), .temp_data(temp_data),
    .cfg_load(cfg_load), .cfg_trigger(cfg_trigger), .cfg_release(cfg_release),
    .cfg_init_dly(cfg_init_dly), .cfg_resp_dly(cfg_resp_dly),
    .cfg_policy_dly(cfg_policy_dly), .cfg_shut_dly(cfg_shut_dly),
    .throttle_o(throttle_o), .phase_o(phase_o),
    .engage_cnt_o(engage_cnt_o), .active_cyc_o(active_cyc_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int ph, input int dwell, input bit mult);
    exp_t e;
    e.ph = ph; e.dwell = dwell; e.mult = mult;
    sb_q.push_back(e);
  endtask

  task automatic feed4(input int a, input int b, input int c, input int d);
    int v[4];
    v = '{a, b, c, d};
    foreach (v[i]) begin
      @(negedge clk);
      temp_valid = 1'b1;
      temp_data  = 8'(v[i]);
    end
    @(negedge clk);
    temp_valid = 1'b0;
  endtask

  task automatic load(input int tr, input int rl, input int ini, input int rsp,
                      input int pol, input int sh);
    @(negedge clk);
    cfg_load = 1'b1;
    cfg_trigger = 8'(tr); cfg_release = 8'(rl);
    cfg_init_dly = 16'(ini); cfg_resp_dly = 16'(rsp);
    cfg_policy_dly = 16'(pol); cfg_shut_dly = 16'(sh);
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wait_phase(input int ph, input string req);
    int n = 0;
    while (phase_o != 3'(ph) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(phase_o == 3'(ph), req, int'(phase_o), ph);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: pops one expected item per finished phase and compares
  int prev_ph = 0;
  int dwell = 0;
  always @(negedge clk) begin
    if (rst) begin
      prev_ph = 0;
      dwell = 0;
    end else if (int'(phase_o) != prev_ph) begin
      exp_t e;
      if (prev_ph == 3) hold_total += dwell;
      if (sb_q.size() == 0) begin
        check(1'b0, "R4 unexpected transition", int'(phase_o), prev_ph);
      end else begin
        e = sb_q.pop_front();
        check(e.ph == prev_ph, "R4 phase order", prev_ph, e.ph);
        if (e.dwell > 0) begin
          if (e.mult)
            check(dwell % e.dwell == 0, "R6 hold is whole policy windows", dwell, e.dwell);
          else
            check(dwell == e.dwell, "R4/R8 phase length", dwell, e.dwell);
        end
      end
      check(throttle_o == (phase_o == 3'd3 || phase_o == 3'd4), "R7 throttle",
            int'(throttle_o), int'(phase_o == 3'd3 || phase_o == 3'd4));
      prev_ph = int'(phase_o);
      dwell = 1;
    end else begin
      dwell++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 40000) begin
      check(1'b0, "watchdog", cyc, 40000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cycles(5);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(phase_o == 3'd0, "R1 phase", int'(phase_o), 0);
    check(!throttle_o, "R1 throttle", int'(throttle_o), 0);
    check(engage_cnt_o == 0 && active_cyc_o == 0, "R1 counters",
          int'(engage_cnt_o + active_cyc_o), 0);

    // R2: one hot sample in a cool window is averaged away (trigger 200)
    feed4(255, 150, 150, 150);
    wait_cycles(10);
    check(phase_o == 3'd0, "R2 spike smoothed", int'(phase_o), 0);
    // R3: average 199 is one below the default trigger
    feed4(199, 199, 199, 202);
    wait_cycles(10);
    check(phase_o == 3'd0, "R3 below trigger", int'(phase_o), 0);

    // R3/R4/R6/R8 full sequence, average exactly at trigger
    load(100, 80, 3, 2, 10, 5);
    push(0, -1, 0); push(1, 3, 0); push(2, 2, 0); push(3, 10, 1); push(4, 5, 0);
    feed4(100, 100, 101, 99);
    wait_phase(3, "R3 engage at trigger");
    // R9: load while busy must be ignored
    load(255, 0, 7, 7, 20, 9);
    wait_cycles(25);
    check(phase_o == 3'd3, "R6 stays above release", int'(phase_o), 3);
    feed4(80, 80, 80, 80);
    wait_cycles(25);
    check(phase_o == 3'd3, "R6 stays at release", int'(phase_o), 3);
    feed4(79, 79, 79, 79);
    wait_phase(4, "R6 leaves below release");
    wait_phase(0, "R8 back to idle");
    wait_cycles(3);
    check(sb_q.size() == 0, "R4 all phases seen", sb_q.size(), 0);
    check(engage_cnt_o == 1, "R10 engage count", int'(engage_cnt_o), 1);
    check(int'(active_cyc_o) == hold_total && hold_total % 10 == 0,
          "R10 active cycles", int'(active_cyc_o), hold_total);

    // R9: old settings still apply (init 3, trigger 100)
    push(0, -1, 0); push(1, 3, 0); push(2, 2, 0); push(3, 10, 1); push(4, 5, 0);
    feed4(120, 120, 120, 120);
    wait_phase(3, "R9 busy load ignored");
    feed4(0, 0, 0, 0);
    wait_phase(0, "R8 idle again");
    wait_cycles(3);
    check(sb_q.size() == 0, "R9 sequence kept old lengths", sb_q.size(), 0);

    // R5: all lengths zero, policy acts as one cycle
    load(100, 80, 0, 0, 0, 0);
    push(0, -1, 0); push(3, 1, 1);
    feed4(120, 120, 120, 120);
    wait_phase(3, "R5 direct to hold");
    wait_cycles(5);
    feed4(0, 0, 0, 0);
    wait_phase(0, "R5 direct to idle");
    wait_cycles(3);
    check(sb_q.size() == 0, "R5 skipped phases", sb_q.size(), 0);
    check(engage_cnt_o == 3, "R10 engage total", int'(engage_cnt_o), 3);
    check(int'(active_cyc_o) == hold_total, "R10 active total", int'(active_cyc_o), hold_total);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule